// File: doc/BRIEF.md
# Static LCD Segment Driver

This block drives a static (one common phase) liquid-crystal panel. It has forty segment outputs and two common outputs. Display bits come in over a three-wire serial link: a data line, a shift clock and a load strobe. Bits are shifted into a holding register. A rising edge on the load strobe copies the whole register into the display register, and only the display register feeds the segment outputs. The last stage of the holding register drives a cascade output. A second or third driver chained from it receives the same stream forty shift clocks later, so one frame of 80 or 120 bits fills two or three drivers.

An on segment is driven in antiphase to the commons, and an off segment is driven in phase with them. This gives a full square wave across lit segments and no net DC across dark ones. A free-running divider counts edges of a slow reference input and provides eight taps. The frame clock input and the blink clock input are normally wired to two of these taps. Active-low enables control blinking, two segment groups and each common.

All logic runs on one system clock. The serial inputs, the reference input and both display clocks are synchronised and edge-detected in that domain. The control enables act directly on the outputs.

Top module: `static_lcd_driver`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_din` into the holding register. The first of forty bits sent ends up in segment 40 (`seg_out[39]`), and the last bit sent ends up in segment 1 (`seg_out[0]`).
- R2: The segment outputs change only when `ser_load` rises, which copies the holding register into the display register. Shift clocks without a load leave the segments unchanged.
- R3: `ser_dout` shows the bit shifted in forty `ser_clk` edges earlier, and shows 0 until forty bits have been shifted after reset.
- R4: While `rst_n` is low, the holding register, the display register and the divider clear to 0. After reset, every segment is off and `ser_dout` and `div_taps` are 0.
- R5: Each enabled common output equals the inverse of `frame_clk`.
- R6: An enabled segment whose display bit is 1 outputs `frame_clk`. One whose display bit is 0 outputs the inverse of `frame_clk`.
- R7: When `seg_lo_en_n` is 1, `seg_out[15:0]` (segments 1 to 16) are forced to 0.
- R8: When `seg_hi_en_n` is 1, `seg_out[39:16]` (segments 17 to 40) are forced to 0.
- R9: When `com_a_en_n` is 1, `com_a` is 0. When `com_b_en_n` is 1, `com_b` is 0. Each enable acts on its own common only.
- R10: While `blink_n` is 0 and `blink_clk` is 1, every segment is driven as off. When `blink_clk` returns to 0, the stored pattern shows again without being reloaded.
- R11: While `blink_n` is 1, `blink_clk` has no effect on the segments.
- R12: `div_taps` bits 0 to 7 show the reference `fin` divided by 16, 32, 64, 128, 256, 8192, 16384 and 32768. Each tap is bit 3, 4, 5, 6, 7, 12, 13 and 14 of a count of `fin` rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| ser_din | input | 1 | Serial display data |
| ser_clk | input | 1 | Serial shift clock |
| ser_load | input | 1 | Load strobe, copies holding to display register on rise |
| fin | input | 1 | Divider reference input |
| frame_clk | input | 1 | LCD frame clock |
| blink_clk | input | 1 | Blink pacing clock |
| blink_n | input | 1 | Active-low blink enable |
| seg_lo_en_n | input | 1 | Active-low enable, segments 1 to 16 |
| seg_hi_en_n | input | 1 | Active-low enable, segments 17 to 40 |
| com_a_en_n | input | 1 | Active-low enable, common A |
| com_b_en_n | input | 1 | Active-low enable, common B |
| ser_dout | output | 1 | Cascade output, last holding stage |
| div_taps | output | 8 | Divided reference taps |
| seg_out | output | 40 | Segment drive, bit i is segment i+1 |
| com_a | output | 1 | Common A drive |
| com_b | output | 1 | Common B drive |

## Verification
The bench targets segment ordering. A design that shifts the wrong way shows every pattern mirrored. It also checks that shifting does not reach the segments before a load, which a design that lets the holding register through would fail. The cascade output is checked bit by bit while a second frame is shifted. A tap taken one stage off would give a stream that is one bit early or late. Group boundaries at segments 16 and 17 and each common enable are checked on their own, so a swapped or shifted boundary shows up. Blink is checked in both clock phases and with blink disabled. The divider is checked after 20 and after 16400 reference edges, which exposes tap positions that are off by one.

// File: rtl/static_lcd_driver.sv
module static_lcd_driver #(
  parameter int NSEG   = 40,
  parameter int LO_GRP = 16,
  parameter int DIV_W  = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_din,
  input  logic            ser_clk,
  input  logic            ser_load,
  input  logic            fin,
  input  logic            frame_clk,
  input  logic            blink_clk,
  input  logic            blink_n,
  input  logic            seg_lo_en_n,
  input  logic            seg_hi_en_n,
  input  logic            com_a_en_n,
  input  logic            com_b_en_n,
  output logic            ser_dout,
  output logic [7:0]      div_taps,
  output logic [NSEG-1:0] seg_out,
  output logic            com_a,
  output logic            com_b
);

  localparam int TAP_LO = 3;
  localparam int TAP_HI = DIV_W - 3;

  logic [2:0]       sclk_q, load_q, fin_q;
  logic [1:0]       din_q, lclk_q, bclk_q;
  logic [NSEG-1:0]  shift_q, disp_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      load_q <= '0;
      fin_q  <= '0;
      din_q  <= '0;
      lclk_q <= '0;
      bclk_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], ser_clk};
      load_q <= {load_q[1:0], ser_load};
      fin_q  <= {fin_q[1:0], fin};
      din_q  <= {din_q[0], ser_din};
      lclk_q <= {lclk_q[0], frame_clk};
      bclk_q <= {bclk_q[0], blink_clk};
    end
  end

  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire load_rise = load_q[1] & ~load_q[2];
  wire fin_rise  = fin_q[1] & ~fin_q[2];
  wire din_s     = din_q[1];
  wire lclk      = lclk_q[1];
  wire bclk_s    = bclk_q[1];
  wire blank     = ~blink_n & bclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      disp_q  <= '0;
      div_q   <= '0;
    end else begin
      if (sclk_rise) shift_q <= {shift_q[NSEG-2:0], din_s};
      if (load_rise) disp_q  <= shift_q;
      if (fin_rise)  div_q   <= div_q + 1'b1;
    end
  end

  assign ser_dout = shift_q[NSEG-1];
  assign div_taps = {div_q[DIV_W-1:TAP_HI], div_q[TAP_LO+4:TAP_LO]};
  assign com_a    = ~com_a_en_n & ~lclk;
  assign com_b    = ~com_b_en_n & ~lclk;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic on;
    assign on = disp_q[i] & ~blank;
    if (i < LO_GRP) begin : g_lo
      assign seg_out[i] = ~seg_lo_en_n & (on ? lclk : ~lclk);
    end else begin : g_hi
      assign seg_out[i] = ~seg_hi_en_n & (on ? lclk : ~lclk);
    end
  end

endmodule

// File: rtl/static_lcd_driver_chk.sv
module static_lcd_driver_chk #(
  parameter int NSEG   = 40,
  parameter int LO_GRP = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk_rise,
  input logic            load_rise,
  input logic            din_s,
  input logic            bclk_s,
  input logic [NSEG-1:0] shift_q,
  input logic [NSEG-1:0] disp_q,
  input logic            ser_dout,
  input logic [NSEG-1:0] seg_out,
  input logic            com_a,
  input logic            com_b,
  input logic            blink_n,
  input logic            seg_lo_en_n,
  input logic            seg_hi_en_n,
  input logic            com_a_en_n,
  input logic            com_b_en_n
);

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shift_q[0] == $past(din_s));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(disp_q));

  p_cascade_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> ser_dout == $past(shift_q[NSEG-2]));

  p_com_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!com_a_en_n && !com_b_en_n) |-> com_a == com_b);

  p_lo_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_lo_en_n |-> seg_out[LO_GRP-1:0] == '0);

  p_hi_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_hi_en_n |-> seg_out[NSEG-1:LO_GRP] == '0);

  p_com_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (com_a_en_n |-> !com_a) and (com_b_en_n |-> !com_b));

  p_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!blink_n && bclk_s && !com_a_en_n && !seg_lo_en_n) |-> seg_out[0] == com_a);

endmodule

bind static_lcd_driver static_lcd_driver_chk #(.NSEG(NSEG), .LO_GRP(LO_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .load_rise(load_rise),
  .din_s(din_s), .bclk_s(bclk_s), .shift_q(shift_q), .disp_q(disp_q),
  .ser_dout(ser_dout), .seg_out(seg_out), .com_a(com_a), .com_b(com_b),
  .blink_n(blink_n), .seg_lo_en_n(seg_lo_en_n), .seg_hi_en_n(seg_hi_en_n),
  .com_a_en_n(com_a_en_n), .com_b_en_n(com_b_en_n));

// File: tb/tb_static_lcd_driver.sv
`timescale 1ns/1ps
module tb_static_lcd_driver;
  localparam int NSEG = 40;

  logic clk = 0, rst_n = 0;
  logic ser_din = 0, ser_clk = 0, ser_load = 0, fin = 0;
  logic frame_clk = 0, blink_clk = 0, blink_n = 1;
  logic seg_lo_en_n = 0, seg_hi_en_n = 0, com_a_en_n = 0, com_b_en_n = 0;
  logic ser_dout, com_a, com_b;
  logic [7:0] div_taps;
  logic [NSEG-1:0] seg_out;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  static_lcd_driver dut (.*);

  localparam logic [NSEG-1:0] PATS [6] = '{
    40'h80_0000_0001, 40'hFF_FFFF_FFFF, 40'hA5_5AA5_5A3C,
    40'h00_0001_0000, 40'h00_0000_8000, 40'h12_3456_789A};

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(logic b);
    ser_din = b; cyc(3); ser_clk = 1; cyc(4); ser_clk = 0; cyc(3);
  endtask

  task automatic send(logic [NSEG-1:0] p);
    for (int k = NSEG-1; k >= 0; k--) shift_bit(p[k]);
  endtask

  task automatic load(); ser_load = 1; cyc(4); ser_load = 0; cyc(4); endtask

  task automatic set_lclk(logic v); frame_clk = v; cyc(4); endtask

  function automatic logic [NSEG-1:0] exp_seg(logic [NSEG-1:0] d);
    logic [NSEG-1:0] r;
    for (int i = 0; i < NSEG; i++) begin
      logic on;
      on = d[i] & ~(~blink_n & blink_clk);
      r[i] = (on ? frame_clk : ~frame_clk) & ~(i < 16 ? seg_lo_en_n : seg_hi_en_n);
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_taps(int n);
    return {n[14], n[13], n[12], n[7:3]};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [NSEG-1:0] cur;
    cyc(3); rst_n = 1; cyc(3);
    set_lclk(1);
    chk("R4 segs off", seg_out, exp_seg('0));
    chk("R4 dout", ser_dout, 0);
    chk("R4 taps", div_taps, 0);
    set_lclk(0);
    chk("R4 segs off low", seg_out, exp_seg('0));

    cur = '0;
    for (int v = 0; v < 6; v++) begin
      send(PATS[v]);
      chk("R2 no change before load", seg_out, exp_seg(cur));
      load(); cur = PATS[v];
      set_lclk(1);
      chk("R1 R6 pattern lclk=1", seg_out, exp_seg(cur));
      chk("R5 com inverse", {com_a, com_b}, 2'b00);
      set_lclk(0);
      chk("R1 R6 pattern lclk=0", seg_out, exp_seg(cur));
      chk("R5 com inverse", {com_a, com_b}, 2'b11);
    end

    for (int j = 0; j < NSEG; j++) begin
      chk("R3 cascade", ser_dout, cur[NSEG-1-j]);
      shift_bit(j[0]);
    end
    chk("R2 shift only", seg_out, exp_seg(cur));

    cur = 40'hFF_FFFF_FFFF; send(cur); load();
    set_lclk(1);
    seg_lo_en_n = 1; cyc(2);
    chk("R7 low group off", seg_out, {24'hFF_FFFF, 16'h0});
    seg_lo_en_n = 0; seg_hi_en_n = 1; cyc(2);
    chk("R8 high group off", seg_out, {24'h0, 16'hFFFF});
    seg_hi_en_n = 0;
    set_lclk(0);
    com_a_en_n = 1; cyc(2);
    chk("R9 com a off", {com_a, com_b}, 2'b01);
    com_a_en_n = 0; com_b_en_n = 1; cyc(2);
    chk("R9 com b off", {com_a, com_b}, 2'b10);
    com_b_en_n = 0;

    cur = PATS[2]; send(cur); load();
    set_lclk(1);
    blink_n = 0; blink_clk = 1; cyc(4);
    chk("R10 blank", seg_out, '0);
    blink_clk = 0; cyc(4);
    chk("R10 restore", seg_out, cur);
    blink_n = 1; blink_clk = 1; cyc(4);
    chk("R11 blink disabled", seg_out, cur);
    blink_clk = 0;

    for (int k = 0; k < 20; k++) begin fin = 1; cyc(1); fin = 0; cyc(1); end
    cyc(4);
    chk("R12 taps 20", div_taps, exp_taps(20));
    for (int k = 0; k < 16380; k++) begin fin = 1; cyc(1); fin = 0; cyc(1); end
    cyc(4);
    chk("R12 taps 16400", div_taps, exp_taps(16400));

    rst_n = 0; cyc(2); rst_n = 1; cyc(2);
    chk("R4 reset clears display", seg_out, exp_seg('0));
    chk("R4 reset clears taps", div_taps, 0);
    load();
    chk("R4 holding cleared", seg_out, exp_seg('0));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule